// File: doc/BRIEF.md
# SDRAM Read Command Sequencer with Open-Row Tracking

This block turns read requests into command sequences for an SDRAM device whose burst length is fixed at eight. Each request carries a bank, a row, a starting column and a beat count from one to eight. The block keeps a table that holds the open row of every bank. When a request hits the open row, the block sends the read command at once. When the request targets a closed bank, the block activates the row and then reads. When another row is open in the target bank, the block closes that row, activates the new row and then reads. It inserts the programmed row-precharge and row-to-column gaps. It waits out the CAS latency before it qualifies the returned data. When the request wants fewer than eight beats, it sends a burst-stop command so that the extra beats never appear on the data bus.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle, so a request is held back from acceptance until the previous read has delivered its last beat. The upstream side must keep `req_valid` and the request fields stable until it sees `req_ready`. Read data leaves on `rd_valid`/`rd_last` without back-pressure, because the SDRAM cannot pause a burst, and the consumer must take every beat in the cycle it is shown. The configuration inputs are sampled when a request is accepted.

Top module: `sdram_rd_seq`

## Requirements
- R1: During reset and after it, `req_ready` is 1, `mem_cmd` is NOP and `rd_valid` is 0. Every bank is marked closed, so the first access to a bank after reset starts with an activate.
- R2: A request whose bank is open on the same row issues a read (code 2) in the first cycle after acceptance, with no precharge and no activate.
- R3: A request to a bank that has a different row open issues a precharge (code 3) in the first cycle after acceptance, then an activate (code 1), then a read.
- R4: A request to a closed bank issues an activate in the first cycle after acceptance, then a read, and no precharge.
- R5: The activate follows the precharge by exactly max(`cfg_trp`,1) cycles.
- R6: The read follows the activate by exactly max(`cfg_trcd`,1) cycles.
- R7: `cfg_cas` selects the CAS latency: 0 gives 2 clocks, and 1 (2.5, rounded up), 2 and 3 give 3 clocks. The first `rd_valid` comes CAS+1 cycles after the read command.
- R8: The block delivers exactly `req_len`+1 beats on consecutive cycles. Beat k carries the `mem_rdata` value that was present CAS+k cycles after the read command. `rd_last` is high only with the final beat.
- R9: When fewer than eight beats are wanted (N = `req_len`+1 < 8), a burst-stop (code 4) is issued exactly N cycles after the read. When all eight beats are wanted, no burst-stop is issued.
- R10: `req_ready` falls in the cycle after acceptance. It stays low until the cycle in which `rd_last` is shown, and it is high in that cycle.
- R11: Command codes are NOP=0, ACT=1, RD=2, PRE=3, BST=4. `mem_bank` carries the target bank with every non-NOP command. `mem_addr` carries the row with ACT and the column with RD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trp | input | 4 | Precharge-to-activate gap in cycles (0 treated as 1) |
| cfg_trcd | input | 4 | Activate-to-read gap in cycles (0 treated as 1) |
| cfg_cas | input | 2 | CAS latency select |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request start column |
| req_len | input | 3 | Beats wanted minus one |
| mem_cmd | output | 3 | SDRAM command code |
| mem_bank | output | BANK_W | Command bank |
| mem_addr | output | ROW_W | Command address (row or column) |
| mem_rdata | input | DATA_W | Read data from the device |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DATA_W | Read beat data |
| rd_last | output | 1 | Final wanted beat |

## Verification
The assertions check properties that must hold on every cycle. They confirm that only legal command codes appear and that an idle sequencer sends nothing. They confirm that a precharge is never followed directly by a read and that an activate is followed only by a NOP or a read. They also check that `req_ready` drops after acceptance and stays low while beats are still to come, and that `rd_last` never appears without `rd_valid`. Only the bench scenarios can show the exact cycle spacing of PRE, ACT, RD and BST for each gap and latency setting. The same holds for which path a given history of open rows selects, and for whether the beat data came from the right cycles.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_BST = 3'd4
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRP,
    ST_TRCD,
    ST_BURST
  } seq_state_e;

  // gap of zero is raised to one cycle
  function automatic logic [3:0] gap_eff(input logic [3:0] g);
    return (g == 4'd0) ? 4'd1 : g;
  endfunction

  // 2.5 is rounded up to 3 whole clocks
  function automatic logic [1:0] cas_clocks(input logic [1:0] sel);
    return (sel == 2'd0) ? 2'd2 : 2'd3;
  endfunction

endpackage

// File: rtl/sdram_open_rows.sv
module sdram_open_rows #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              q_open,
  output logic              q_hit,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ROW_W-1:0]  wr_row
);
  localparam int NUM_BANKS = 1 << BANK_W;

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
        row_q[g]  <= '0;
      end else if (wr_en && wr_bank == BANK_W'(g)) begin
        open_q[g] <= 1'b1;
        row_q[g]  <= wr_row;
      end
    end
  end

  assign q_open = open_q[q_bank];
  assign q_hit  = q_open && (row_q[q_bank] == q_row);
endmodule

// File: rtl/sdram_beat_capture.sv
module sdram_beat_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_burst,
  input  logic [3:0]        tick,
  input  logic [1:0]        lat,
  input  logic [2:0]        nm1,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              burst_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  logic [3:0] first_t, last_t;
  logic       in_win;

  assign first_t    = {2'b00, lat};
  assign last_t     = first_t + {1'b0, nm1};
  assign in_win     = in_burst && (tick >= first_t) && (tick <= last_t);
  assign burst_done = in_burst && (tick == last_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= in_win;
      rd_last  <= burst_done;
      if (in_win) rd_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_trp,
  input  logic [3:0]        cfg_trcd,
  input  logic [1:0]        cfg_cas,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [2:0]        req_len,
  output logic [2:0]        mem_cmd,
  output logic [BANK_W-1:0] mem_bank,
  output logic [ROW_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  localparam logic [2:0] FULL_M1 = 3'd7;

  seq_state_e        st;
  logic [3:0]        cnt, tick, trcd_q;
  logic [1:0]        lat_q;
  logic [2:0]        nm1_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  sdram_cmd_e        cmd_q;
  logic [ROW_W-1:0]  addr_q;

  logic              accept, q_open, q_hit, tbl_we, burst_done;
  logic [BANK_W-1:0] tbl_bank;
  logic [ROW_W-1:0]  tbl_row;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sdram_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .q_bank(req_bank), .q_row(req_row), .q_open(q_open), .q_hit(q_hit),
    .wr_en(tbl_we), .wr_bank(tbl_bank), .wr_row(tbl_row)
  );

  // the table is written whenever an activate is issued
  always_comb begin
    tbl_we   = 1'b0;
    tbl_bank = bank_q;
    tbl_row  = row_q;
    if (accept && !q_open) begin
      tbl_we   = 1'b1;
      tbl_bank = req_bank;
      tbl_row  = req_row;
    end else if (st == ST_TRP && cnt == 4'd0) begin
      tbl_we = 1'b1;
    end
  end

  sdram_beat_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .in_burst(st == ST_BURST), .tick(tick), .lat(lat_q), .nm1(nm1_q),
    .mem_rdata(mem_rdata), .burst_done(burst_done),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      tick   <= '0;
      trcd_q <= 4'd1;
      lat_q  <= 2'd2;
      nm1_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      unique case (st)
        ST_IDLE: if (accept) begin
          bank_q <= req_bank;
          row_q  <= req_row;
          col_q  <= req_col;
          nm1_q  <= req_len;
          lat_q  <= cas_clocks(cfg_cas);
          trcd_q <= gap_eff(cfg_trcd);
          if (q_hit) begin
            cmd_q  <= CMD_RD;
            addr_q <= ROW_W'(req_col);
            tick   <= '0;
            st     <= ST_BURST;
          end else if (q_open) begin
            cmd_q  <= CMD_PRE;
            addr_q <= '0;
            cnt    <= gap_eff(cfg_trp) - 4'd1;
            st     <= ST_TRP;
          end else begin
            cmd_q  <= CMD_ACT;
            addr_q <= req_row;
            cnt    <= gap_eff(cfg_trcd) - 4'd1;
            st     <= ST_TRCD;
          end
        end
        ST_TRP: begin
          if (cnt == 4'd0) begin
            cmd_q  <= CMD_ACT;
            addr_q <= row_q;
            cnt    <= trcd_q - 4'd1;
            st     <= ST_TRCD;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        ST_TRCD: begin
          if (cnt == 4'd0) begin
            cmd_q  <= CMD_RD;
            addr_q <= ROW_W'(col_q);
            tick   <= '0;
            st     <= ST_BURST;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        ST_BURST: begin
          tick <= tick + 4'd1;
          if (tick == {1'b0, nm1_q} && nm1_q != FULL_M1) cmd_q <= CMD_BST;
          if (burst_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_cmd  = cmd_q;
  assign mem_bank = bank_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] mem_cmd,
  input logic       rd_valid,
  input logic       rd_last
);
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd <= 3'd4); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cmd == 3'd0); // R1
  AST_PRE_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == 3'd3 |=> mem_cmd == 3'd0 || mem_cmd == 3'd1); // R5
  AST_ACT_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == 3'd1 |=> mem_cmd == 3'd0 || mem_cmd == 3'd2); // R6
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R10
  AST_BUSY_MID_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_last |-> !req_ready); // R10
endmodule

bind sdram_rd_seq sdram_rd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_cmd(mem_cmd), .rd_valid(rd_valid), .rd_last(rd_last)
);

// File: tb/test_sdram_rd_seq.sv
`timescale 1ns/1ps
module test_sdram_rd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trp = 4'd1, cfg_trcd = 4'd1;
  logic [1:0]  cfg_cas = 2'd0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [2:0]  req_len = '0;
  logic [2:0]  mem_cmd;
  logic [1:0]  mem_bank;
  logic [12:0] mem_addr;
  logic [15:0] mem_rdata, rd_data;
  logic        rd_valid, rd_last;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_rdata = cyc[15:0];

  sdram_rd_seq i_sdram_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
    .cfg_cas(cfg_cas), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_len(req_len), .mem_cmd(mem_cmd), .mem_bank(mem_bank),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind: 0 hit, 1 row conflict, 2 closed bank
  // fields: bank[39:38] row[37:25] col[24:15] len[14:12] trp[11:8] trcd[7:4] cas[3:2] kind[1:0]
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 13'd5,   10'd0,  3'd7, 4'd2, 4'd3, 2'd0, 2'd2},
    {2'd0, 13'd5,   10'd3,  3'd0, 4'd2, 4'd3, 2'd1, 2'd0},
    {2'd0, 13'd9,   10'd8,  3'd3, 4'd1, 4'd1, 2'd2, 2'd1},
    {2'd1, 13'd9,   10'd16, 3'd1, 4'd4, 4'd2, 2'd0, 2'd2},
    {2'd1, 13'd9,   10'd21, 3'd7, 4'd4, 4'd2, 2'd2, 2'd0},
    {2'd0, 13'd9,   10'd40, 3'd5, 4'd1, 4'd1, 2'd3, 2'd0},
    {2'd1, 13'd2,   10'd7,  3'd2, 4'd5, 4'd4, 2'd1, 2'd1},
    {2'd3, 13'd2,   10'd9,  3'd4, 4'd3, 4'd1, 2'd0, 2'd2},
    {2'd2, 13'd100, 10'd1,  3'd6, 4'd0, 4'd0, 2'd0, 2'd2},
    {2'd2, 13'd101, 10'd2,  3'd0, 4'd0, 4'd0, 2'd2, 2'd1},
    {2'd3, 13'd2,   10'd5,  3'd7, 4'd6, 4'd6, 2'd1, 2'd0}
  };

  task automatic run_req(input logic [39:0] v);
    int kind, n, trp_e, trcd_e, lat, t0;
    int t_pre = -1, t_act = -1, t_rd = -1, t_bst = -1, t_first = -1;
    int beats = 0, bad_data = 0, bad_ready = 0, bad_bank = 0, bad_addr = 0;
    bit fin = 0, ready_at_last = 0;
    kind   = int'(v[1:0]);
    n      = int'(v[14:12]) + 1;
    trp_e  = (v[11:8] == 0) ? 1 : int'(v[11:8]);
    trcd_e = (v[7:4] == 0) ? 1 : int'(v[7:4]);
    lat    = (v[3:2] == 0) ? 2 : 3;
    @(negedge clk);
    req_bank = v[39:38]; req_row = v[37:25]; req_col = v[24:15];
    req_len = v[14:12]; cfg_trp = v[11:8]; cfg_trcd = v[7:4]; cfg_cas = v[3:2];
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R10 ready before accept", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t0 = cyc;
    for (int i = 0; i < 60 && !fin; i++) begin
      if (mem_cmd != 3'd0 && mem_bank != v[39:38]) bad_bank++;
      case (mem_cmd)
        3'd3: t_pre = cyc;
        3'd1: begin t_act = cyc; if (mem_addr != v[37:25]) bad_addr++; end
        3'd2: begin t_rd = cyc; if (mem_addr != 13'(v[24:15])) bad_addr++; end
        3'd4: t_bst = cyc;
        default: ;
      endcase
      if (rd_valid) begin
        if (t_first < 0) t_first = cyc;
        if (rd_data != 16'(t_rd + lat + beats)) bad_data++;
        beats++;
        if (rd_last) begin fin = 1; ready_at_last = req_ready; end
      end
      if (!fin && req_ready) bad_ready++;
      if (!fin) @(negedge clk);
    end
    check(fin, "R8 burst completed", int'(fin), 1);
    if (kind == 0) begin
      check(t_rd == t0 && t_act < 0 && t_pre < 0, "R2 hit reads at once", t_rd - t0, 0);
    end else if (kind == 1) begin
      check(t_pre == t0, "R3 precharge first", t_pre - t0, 0);
      check(t_act - t_pre == trp_e, "R5 precharge-to-activate gap", t_act - t_pre, trp_e);
      check(t_rd - t_act == trcd_e, "R6 activate-to-read gap", t_rd - t_act, trcd_e);
    end else begin
      check(t_act == t0 && t_pre < 0, "R4 activate first, no precharge", t_act - t0, 0);
      check(t_rd - t_act == trcd_e, "R6 activate-to-read gap", t_rd - t_act, trcd_e);
    end
    check(bad_bank == 0 && bad_addr == 0, "R11 bank/address with commands", bad_bank + bad_addr, 0);
    check(t_first - t_rd == lat + 1, "R7 first beat after CAS", t_first - t_rd, lat + 1);
    check(beats == n, "R8 beat count", beats, n);
    check(bad_data == 0, "R8 beat data", bad_data, 0);
    if (n < 8) check(t_bst - t_rd == n, "R9 burst-stop placement", t_bst - t_rd, n);
    else       check(t_bst < 0, "R9 no burst-stop on full burst", t_bst, -1);
    check(bad_ready == 0 && ready_at_last, "R10 ready low while busy", bad_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    check(mem_cmd == 3'd0, "R1 NOP in reset", int'(mem_cmd), 0);
    check(rd_valid == 1'b0, "R1 no data in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && mem_cmd == 3'd0, "R1 idle after reset", int'(mem_cmd), 0);
    for (int k = 0; k < NV; k++) run_req(VEC[k]);
    // reset closes every bank: bank0 row9 was open, now an activate is required
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    run_req({2'd0, 13'd9, 10'd4, 3'd2, 4'd2, 4'd2, 2'd0, 2'd2}); // R1
    // same row again is now a hit
    run_req({2'd0, 13'd9, 10'd6, 3'd0, 4'd2, 4'd2, 2'd1, 2'd0});
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule